// File: doc/BRIEF.md
# Vector Length Clamp and Lane Enable Unit

This unit turns a requested vector length into the length a variable-length vector datapath actually uses. The request arrives as a 64-bit general-purpose register value counting bytes. A 5-bit length-register field selects where that value came from, and an element size code gives the operand width. The unit clamps the request to the current maximum length and turns non-positive requests into an empty vector. It derives the number of whole elements and produces a per-byte lane-enable bitmap covering exactly those elements.

The hardware maximum `MAX_BYTES` is a power of two of at least 16 bytes. Software can lower the active maximum at run time by writing a limit register, and every later clamp uses the lowered value. A length field value of 31 never names a register. It requests a single scalar element of the operand size, whatever the register value or the limit. Results appear one clock after a valid request, with the valid flag delayed alongside them. The unit is meant to sit in the operand stage in front of a vector load, store or arithmetic unit.

Top module: `vec_len_unit`

## Requirements
- R1: After synchronous reset, `out_valid`, `eff_len`, `elem_cnt` and `lane_en` are zero, and the active limit equals `MAX_BYTES`.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `eff_len`, `elem_cnt` and `lane_en` keep their previous values.
- R3: For a non-scalar request `req_len` with 0 < `req_len` <= active limit, `eff_len` equals `req_len`, including lengths that are not powers of two.
- R4: For a non-scalar request with bit 63 clear and `req_len` greater than the active limit (unsigned compare), `eff_len` equals the active limit.
- R5: For a non-scalar request that is zero or has bit 63 set (negative as signed), `eff_len`, `elem_cnt` and `lane_en` are all zero.
- R6: `elem_cnt` equals `eff_len` divided by the element size, rounded down. `elem_code` values 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes, and codes 5 to 7 are treated as 1 byte.
- R7: `lane_en[k]` is 1 exactly when k < `elem_cnt` × element size, so the bytes of a partial trailing element are disabled.
- R8: When `len_sel` is 31, the result is one scalar element: `eff_len` equals the element size and `elem_cnt` is 1, whatever the values of `req_len` and the active limit.
- R9: A cycle with `lim_we` high sets the active limit to `lim_wdata`, or to `MAX_BYTES` if `lim_wdata` is larger. A request accepted in that same cycle is still clamped against the old limit, and requests in later cycles are clamped against the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| req_len | input | 64 | Requested length in bytes, read as signed for the sign test |
| len_sel | input | 5 | Length-register field; 31 selects a scalar |
| elem_code | input | 3 | Element size code (0..4 → 1..16 bytes) |
| lim_we | input | 1 | Write strobe for the run-time limit |
| lim_wdata | input | 64 | New run-time limit in bytes |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| eff_len | output | 7 | Effective byte length after clamping |
| elem_cnt | output | 7 | Number of whole elements |
| lane_en | output | 64 | Per-byte lane enable |

## Verification
The hardest case to reach is a limit write landing in the same cycle as a request. The request must still use the old limit, while the request in the very next cycle must already see the new one. The stimulus drives a write strobe and an over-long request together and then repeats the request right after. It also lowers the limit below the element size and sends scalar requests with huge or negative register values, so that a scalar that is clamped, or that reads the register, shows up at the ports. A pseudo-random phase mixes limit writes, idle cycles, negative values and odd lengths against every element code.

// File: rtl/vlu_pkg.sv
package vlu_pkg;

  // Element size code -> log2 of element size in bytes.
  // Codes above 4 are reserved and behave as single-byte elements.
  function automatic logic [2:0] elem_shift(input logic [2:0] code);
    if (code <= 3'd4) begin
      return code;
    end
    return 3'd0;
  endfunction

endpackage

// File: rtl/vlu_limit_reg.sv
module vlu_limit_reg #(
  parameter int MAX_BYTES = 64,
  parameter int REQ_W     = 64,
  localparam int LEN_W    = $clog2(MAX_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REQ_W-1:0] wdata,
  output logic [LEN_W-1:0] cur_lim
);

  localparam logic [REQ_W-1:0] MAX_WIDE = REQ_W'(MAX_BYTES);
  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(MAX_BYTES);

  logic [LEN_W-1:0] sat_val;

  always_comb begin
    if (wdata > MAX_WIDE) begin
      sat_val = MAX_LEN;
    end else begin
      sat_val = wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_lim <= MAX_LEN;
    end else if (we) begin
      cur_lim <= sat_val;
    end
  end

  AST_LIMIT_CAPPED: assert property (@(posedge clk) disable iff (rst)
    cur_lim <= MAX_LEN);  // R9

  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cur_lim));  // R9

endmodule

// File: rtl/vlu_clamp.sv
module vlu_clamp
  import vlu_pkg::*;
#(
  parameter int MAX_BYTES  = 64,
  parameter int REQ_W      = 64,
  parameter int SEL_W      = 5,
  parameter int SCALAR_SEL = 31,
  localparam int LEN_W     = $clog2(MAX_BYTES) + 1
) (
  input  logic [REQ_W-1:0] req,
  input  logic [SEL_W-1:0] sel,
  input  logic [2:0]       code,
  input  logic [LEN_W-1:0] lim,
  output logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] whole
);

  logic [2:0]       shift;
  logic [LEN_W-1:0] size_b;
  logic             is_scalar;
  logic             non_pos;
  logic             too_long;

  assign shift     = elem_shift(code);
  assign size_b    = LEN_W'(1) << shift;
  assign is_scalar = (sel == SEL_W'(SCALAR_SEL));
  assign non_pos   = req[REQ_W-1] || (req == '0);
  assign too_long  = (req > REQ_W'(lim));

  always_comb begin
    if (is_scalar) begin
      len = size_b;
    end else if (non_pos) begin
      len = '0;
    end else if (too_long) begin
      len = lim;
    end else begin
      len = req[LEN_W-1:0];
    end
  end

  assign cnt   = len >> shift;
  assign whole = cnt << shift;

endmodule

// File: rtl/vlu_lane_mask.sv
module vlu_lane_mask #(
  parameter int MAX_BYTES = 64,
  localparam int LEN_W    = $clog2(MAX_BYTES) + 1
) (
  input  logic [LEN_W-1:0]     whole_len,
  output logic [MAX_BYTES-1:0] mask
);

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    assign mask[g] = (whole_len > LEN_W'(g));
  end

endmodule

// File: rtl/vec_len_unit.sv
module vec_len_unit #(
  parameter int MAX_BYTES  = 64,
  parameter int REQ_W      = 64,
  parameter int SEL_W      = 5,
  parameter int SCALAR_SEL = 31,
  localparam int LEN_W     = $clog2(MAX_BYTES) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [REQ_W-1:0]     req_len,
  input  logic [SEL_W-1:0]     len_sel,
  input  logic [2:0]           elem_code,
  input  logic                 lim_we,
  input  logic [REQ_W-1:0]     lim_wdata,
  output logic                 out_valid,
  output logic [LEN_W-1:0]     eff_len,
  output logic [LEN_W-1:0]     elem_cnt,
  output logic [MAX_BYTES-1:0] lane_en
);

  logic [LEN_W-1:0]     cur_lim;
  logic [LEN_W-1:0]     len_c;
  logic [LEN_W-1:0]     cnt_c;
  logic [LEN_W-1:0]     whole_c;
  logic [MAX_BYTES-1:0] mask_c;

  vlu_limit_reg #(
    .MAX_BYTES(MAX_BYTES),
    .REQ_W    (REQ_W)
  ) u_limit (
    .clk    (clk),
    .rst    (rst),
    .we     (lim_we),
    .wdata  (lim_wdata),
    .cur_lim(cur_lim)
  );

  vlu_clamp #(
    .MAX_BYTES (MAX_BYTES),
    .REQ_W     (REQ_W),
    .SEL_W     (SEL_W),
    .SCALAR_SEL(SCALAR_SEL)
  ) u_clamp (
    .req  (req_len),
    .sel  (len_sel),
    .code (elem_code),
    .lim  (cur_lim),
    .len  (len_c),
    .cnt  (cnt_c),
    .whole(whole_c)
  );

  vlu_lane_mask #(
    .MAX_BYTES(MAX_BYTES)
  ) u_mask (
    .whole_len(whole_c),
    .mask     (mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      eff_len   <= '0;
      elem_cnt  <= '0;
      lane_en   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        eff_len  <= len_c;
        elem_cnt <= cnt_c;
        lane_en  <= mask_c;
      end
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(eff_len) && $stable(lane_en)));  // R2

  AST_CLAMP_TO_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (len_sel != SEL_W'(SCALAR_SEL)) && !req_len[REQ_W-1] &&
     (req_len >= REQ_W'(cur_lim))) |=> (eff_len == $past(cur_lim)));  // R4

  AST_NEG_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (len_sel != SEL_W'(SCALAR_SEL)) && req_len[REQ_W-1])
    |=> ((eff_len == '0) && (lane_en == '0)));  // R5

  AST_LANE_PREFIX: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((({1'b0, lane_en} + 1'b1) & {1'b0, lane_en}) == '0));  // R7

  AST_LANES_FIT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(lane_en) <= int'(eff_len)));  // R7

  AST_SCALAR_ONE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (len_sel == SEL_W'(SCALAR_SEL))) |=> (elem_cnt == LEN_W'(1)));  // R8

endmodule

// File: tb/test_vec_len_unit.sv
module test_vec_len_unit;

  localparam int MAX   = 64;
  localparam int LEN_W = $clog2(MAX) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [63:0]      req_len = '0;
  logic [4:0]       len_sel = '0;
  logic [2:0]       elem_code = '0;
  logic             lim_we = 1'b0;
  logic [63:0]      lim_wdata = '0;
  logic             out_valid;
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W-1:0] elem_cnt;
  logic [MAX-1:0]   lane_en;

  always #2 clk = ~clk;  // 250 MHz

  vec_len_unit #(.MAX_BYTES(MAX)) i_vec_len_unit (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .req_len  (req_len),
    .len_sel  (len_sel),
    .elem_code(elem_code),
    .lim_we   (lim_we),
    .lim_wdata(lim_wdata),
    .out_valid(out_valid),
    .eff_len  (eff_len),
    .elem_cnt (elem_cnt),
    .lane_en  (lane_en)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  int          lim_model = MAX;
  logic        exp_v = 1'b0;
  int          exp_len = 0;
  int          exp_cnt = 0;
  logic [MAX-1:0] exp_lanes = '0;
  string       exp_tag = "R1";

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_lanes(input string tag, input logic [MAX-1:0] act, input logic [MAX-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s lane_en: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference: length, count and lanes of one request.
  function automatic void model(input logic [63:0] req, input logic [4:0] sel,
                                input logic [2:0] code, output int len,
                                output int cnt, output logic [MAX-1:0] lanes);
    int sz;
    int whole;
    sz = (code <= 3'd4) ? (1 << code) : 1;
    if (sel == 5'd31) len = sz;
    else if (req[63] || req == 64'd0) len = 0;
    else if (req > 64'(lim_model)) len = lim_model;
    else len = int'(req);
    cnt = len / sz;
    whole = cnt * sz;
    for (int k = 0; k < MAX; k++) lanes[k] = (k < whole);
  endfunction

  task automatic compare_all();
    chk(exp_tag, "out_valid", longint'(out_valid), longint'(exp_v));
    chk(exp_tag, "eff_len", longint'(eff_len), longint'(exp_len));
    chk(exp_tag, "elem_cnt", longint'(elem_cnt), longint'(exp_cnt));
    chk_lanes(exp_tag, lane_en, exp_lanes);
  endtask

  // Compare the previous cycle's result, then drive the next cycle.
  task automatic step(input logic v, input logic [63:0] req, input logic [4:0] sel,
                      input logic [2:0] code, input logic we, input logic [63:0] wd,
                      input string tag);
    int l;
    int c;
    logic [MAX-1:0] m;
    @(negedge clk);
    compare_all();
    in_valid  = v;
    req_len   = req;
    len_sel   = sel;
    elem_code = code;
    lim_we    = we;
    lim_wdata = wd;
    if (v) begin
      model(req, sel, code, l, c, m);
      exp_len = l;
      exp_cnt = c;
      exp_lanes = m;
    end
    exp_v = v;
    exp_tag = tag;
    if (we) lim_model = (wd > 64'(MAX)) ? MAX : int'(wd);
  endtask

  task automatic req(input logic [63:0] r, input logic [2:0] code, input string tag);
    step(1'b1, r, 5'd3, code, 1'b0, 64'd0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "out_valid", longint'(out_valid), 0);
    chk("R1", "eff_len", longint'(eff_len), 0);
    chk("R1", "elem_cnt", longint'(elem_cnt), 0);
    chk_lanes("R1", lane_en, '0);
    // R1: limit resets to the hardware maximum
    req(64'd200, 3'd0, "R1");
    // R3: in-range byte lengths
    req(64'd37, 3'd0, "R3");
    req(64'd64, 3'd0, "R3");
    req(64'd1, 3'd0, "R3");
    // R4: clamping
    req(64'd65, 3'd0, "R4");
    req(64'd1000, 3'd1, "R4");
    req(64'h4000_0000_0000_0000, 3'd3, "R4");
    // R5: zero and negative
    req(64'd0, 3'd0, "R5");
    req('1, 3'd2, "R5");
    req(64'h8000_0000_0000_0000, 3'd0, "R5");
    // R6: every element code
    for (int c = 0; c < 8; c++) req(64'd64, 3'(c), "R6");
    // R7: partial trailing elements
    req(64'd37, 3'd2, "R7");
    req(64'd37, 3'd3, "R7");
    req(64'd31, 3'd4, "R7");
    req(64'd15, 3'd4, "R7");
    // R2: idle cycles hold data, back-to-back requests
    step(1'b0, 64'd5, 5'd3, 3'd0, 1'b0, 64'd0, "R2");
    step(1'b0, 64'd9, 5'd3, 3'd0, 1'b0, 64'd0, "R2");
    req(64'd10, 3'd1, "R2");
    req(64'd11, 3'd0, "R2");
    // R8: scalar field ignores value and limit
    step(1'b1, '1, 5'd31, 3'd3, 1'b0, 64'd0, "R8");
    step(1'b1, 64'd0, 5'd31, 3'd4, 1'b0, 64'd0, "R8");
    // R9: write in the same cycle as a request uses the old limit
    step(1'b1, 64'd50, 5'd3, 3'd0, 1'b1, 64'd20, "R9");
    req(64'd50, 3'd0, "R9");
    req(64'd17, 3'd2, "R9");
    step(1'b1, 64'd100, 5'd3, 3'd0, 1'b1, 64'd1000, "R9");
    req(64'd100, 3'd0, "R9");
    step(1'b0, 64'd0, 5'd3, 3'd0, 1'b1, 64'd4, "R9");
    step(1'b1, 64'h7fff_ffff_ffff_ffff, 5'd31, 3'd3, 1'b0, 64'd0, "R8");
    req(64'd9, 3'd0, "R9");
    step(1'b0, 64'd0, 5'd3, 3'd0, 1'b1, 64'd0, "R9");
    req(64'd5, 3'd0, "R9");
    step(1'b0, 64'd0, 5'd3, 3'd0, 1'b1, 64'd64, "R9");
    // R7: mixed pseudo-random phase
    begin
      logic [63:0] rnd = 64'h1234_5678_9abc_def1;
      for (int i = 0; i < 400; i++) begin
        logic [63:0] r;
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >> 7);
        rnd = rnd ^ (rnd << 17);
        r = (rnd[9:8] == 2'd1) ? rnd : 64'(rnd[6:0]);
        step(rnd[40] | rnd[41], r, (rnd[12:10] == 3'd0) ? 5'd31 : rnd[20:16] % 5'd31,
             rnd[30:28], rnd[50:47] == 4'd0, 64'(rnd[56:51]), "R7");
      end
    end
    step(1'b0, 64'd0, 5'd3, 3'd0, 1'b0, 64'd0, "R2");
    step(1'b0, 64'd0, 5'd3, 3'd0, 1'b0, 64'd0, "R2");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule